// File: doc/BRIEF.md
# Bipolar Substitution Decoder with Violation Flag

This block sits behind a line receiver's clock and data recovery. It takes one positive-rail bit and one negative-rail bit per bit period, qualified by a bit-rate clock enable. In decoding mode it recognises the zero-substitution codes of HDB3 or B3ZS, turns them back into zeros, and produces NRZ data on the positive output. A one-bit line-code-violation flag appears on the negative output, aligned with the bit that broke the coding rules. In pass-through mode both rails travel to the outputs unchanged.

The decoder keeps a short window of past symbols, the polarity of the last ordinary pulse, the parity of ordinary pulses since the last violation pulse, and the length of the current zero run. With these it separates four cases: valid substitutions, bipolar violations, substitutions with the wrong parity (coding violations), and zero runs that are too long. A fixed-depth delay line lets a substitution that has already been taken in be cleared before it reaches the output. The code select and the mode select are meant to stay static between resets.

Top module: `bsd_decoder`

## Requirements
- R1: While `rst_n` is low, both outputs are low. Reset sets the last-pulse polarity to negative, the pulse parity to even, the zero-run count to zero and the symbol window to all zeros.
- R2: The result for the bit sampled at enabled edge n is on the outputs after enabled edge n+L-1. L is 4 with `code_hdb3`=1 and 3 with `code_hdb3`=0. Data and flag stay aligned. Edges with `bit_en` low change nothing.
- R3: With `nrz_mode`=0, `pos_out` and `neg_out` repeat `pos_in` and `neg_in` after the same latency. Nothing is removed and nothing is flagged.
- R4: With `nrz_mode`=1, a single-rail pulse decodes as 1 and no pulse decodes as 0. Data goes on `pos_out` and the violation flag on `neg_out`. An alternating-polarity stream gives ones with no flag.
- R5: A single-rail pulse is a violation pulse V when its polarity equals the polarity of the most recent single-rail pulse that was not itself a V. Straight after reset that polarity is negative.
- R6: HDB3: a V is a valid substitution when the two previous symbols are zeros, the third previous symbol is zero or a single-rail pulse, and the pulse parity is odd. V decodes as 0, and a single-rail pulse three symbols back is also cleared to 0.
- R7: B3ZS: a V is a valid substitution when the previous symbol is zero, the second previous symbol is zero or a single-rail pulse, and the pulse parity is odd. V decodes as 0, and a single-rail pulse two symbols back is also cleared to 0.
- R8: A V whose required zeros are not all zero, or whose lead symbol is a double-rail pulse, is a bipolar violation. It decodes as 1 and is flagged.
- R9: A V with the required zeros in place but even pulse parity is a coding violation. It decodes as 1 and is flagged.
- R10: Each single-rail pulse that is not a V toggles the pulse parity. Every V clears it to even, valid or not.
- R11: The L-th consecutive zero is flagged as an excessive-zeros error, and the count then restarts. Any pulse ends the run.
- R12: A pulse on both rails in one bit decodes as 1 and is flagged. It leaves polarity and parity unchanged and ends the zero run.
- R13: Each flag lasts exactly one bit period and belongs to exactly one decoded bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_en | input | 1 | Bit-rate clock enable; one symbol per enabled edge |
| code_hdb3 | input | 1 | 1 selects HDB3, 0 selects B3ZS |
| nrz_mode | input | 1 | 1 selects decoding, 0 selects pass-through |
| pos_in | input | 1 | Positive-rail pulse of the current bit |
| neg_in | input | 1 | Negative-rail pulse of the current bit |
| pos_out | output | 1 | NRZ data, or the delayed positive rail in pass-through |
| neg_out | output | 1 | Violation flag, or the delayed negative rail in pass-through |

## Verification
The bench builds the decoder with its default spans, 4 for HDB3 and 3 for B3ZS. These defaults make the delay line four stages long, with a tap chosen at run time. One build therefore reaches both codes, both latencies, and a lead-pulse clear that lands on either the third or the fourth stage. Directed streams cover valid substitutions of both forms, bipolar and coding violations, zero-run overflow, double-rail pulses and enable gaps. Long pseudo-random symbol streams in both codes and both modes then stress the interaction of parity, polarity and the zero-run count.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  // Symbol on the two rails, packed as {positive, negative}
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_NEG  = 2'b01,
    SYM_POS  = 2'b10,
    SYM_BOTH = 2'b11
  } sym_e;
endpackage

// File: rtl/bsd_classify.sv
module bsd_classify
  import bsd_pkg::*;
#(
  parameter int unsigned HDB3_SPAN = 4,
  parameter int unsigned B3ZS_SPAN = 3,
  parameter int unsigned SPAN_MAX  = 4,
  parameter int unsigned ZC_W      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic sel_hdb3,
  input  logic rail_p,
  input  logic rail_n,
  output logic dec_bit,
  output logic err_bit,
  output logic drop_lead
);
  localparam int unsigned HIST_N = SPAN_MAX - 1;

  sym_e            hist_q [1:HIST_N];
  sym_e            hist_d [1:HIST_N];
  logic            last_pos_q, last_pos_d;
  logic            par_q, par_d;
  logic [ZC_W-1:0] zc_q, zc_d;

  sym_e            sym;
  logic [ZC_W-1:0] span_c;
  logic            zeros_ok;
  sym_e            lead;
  logic            pol;

  assign sym    = sym_e'({rail_p, rail_n});
  assign span_c = sel_hdb3 ? ZC_W'(HDB3_SPAN) : ZC_W'(B3ZS_SPAN);
  assign pol    = rail_p;

  // Substitution context taken from the symbol window
  always_comb begin
    zeros_ok = 1'b1;
    lead     = SYM_ZERO;
    for (int i = 1; i <= HIST_N; i++) begin
      if ((ZC_W'(i + 2) <= span_c) && (hist_q[i] != SYM_ZERO)) zeros_ok = 1'b0;
      if (ZC_W'(i + 1) == span_c) lead = hist_q[i];
    end
  end

  // Next-state and per-symbol classification
  always_comb begin
    dec_bit    = 1'b0;
    err_bit    = 1'b0;
    drop_lead  = 1'b0;
    last_pos_d = last_pos_q;
    par_d      = par_q;
    zc_d       = zc_q;
    hist_d[1]  = sym;
    for (int i = 2; i <= HIST_N; i++) hist_d[i] = hist_q[i-1];
    if (bit_en) begin
      unique case (sym)
        SYM_BOTH: begin
          dec_bit = 1'b1;
          err_bit = 1'b1;
          zc_d    = '0;
        end
        SYM_POS, SYM_NEG: begin
          zc_d = '0;
          if (pol == last_pos_q) begin
            par_d = 1'b0;
            if (zeros_ok && (lead != SYM_BOTH) && par_q) begin
              drop_lead = (lead != SYM_ZERO);
            end else begin
              dec_bit = 1'b1;
              err_bit = 1'b1;
            end
          end else begin
            dec_bit    = 1'b1;
            par_d      = ~par_q;
            last_pos_d = pol;
          end
        end
        default: begin
          if (zc_q + 1'b1 == span_c) begin
            err_bit = 1'b1;
            zc_d    = '0;
          end else begin
            zc_d = zc_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos_q <= 1'b0;
      par_q      <= 1'b0;
      zc_q       <= '0;
      for (int i = 1; i <= HIST_N; i++) hist_q[i] <= SYM_ZERO;
    end else if (bit_en) begin
      last_pos_q <= last_pos_d;
      par_q      <= par_d;
      zc_q       <= zc_d;
      for (int i = 1; i <= HIST_N; i++) hist_q[i] <= hist_d[i];
    end
  end
endmodule

// File: rtl/bsd_align.sv
module bsd_align #(
  parameter int unsigned HDB3_SPAN = 4,
  parameter int unsigned B3ZS_SPAN = 3,
  parameter int unsigned SPAN_MAX  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic sel_hdb3,
  input  logic nrz_mode,
  input  logic dec_bit,
  input  logic err_bit,
  input  logic drop_lead,
  input  logic rail_p,
  input  logic rail_n,
  output logic out_p,
  output logic out_n
);
  logic [SPAN_MAX:1] dat_q, dat_d;
  logic [SPAN_MAX:1] aux_q, aux_d;
  logic              drop;

  assign drop     = nrz_mode & drop_lead;
  assign dat_d[1] = nrz_mode ? dec_bit : rail_p;
  assign aux_d[1] = nrz_mode ? err_bit : rail_n;

  // Each stage may be the output tap for one code; a lead pulse is cleared
  // as it moves onto the tap stage of the selected code.
  for (genvar g = 2; g <= SPAN_MAX; g++) begin : g_stage
    localparam bit TAP_H = (g == HDB3_SPAN);
    localparam bit TAP_B = (g == B3ZS_SPAN);
    logic clr;
    assign clr      = drop && (sel_hdb3 ? TAP_H : TAP_B);
    assign dat_d[g] = clr ? 1'b0 : dat_q[g-1];
    assign aux_d[g] = aux_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      aux_q <= '0;
    end else if (bit_en) begin
      dat_q <= dat_d;
      aux_q <= aux_d;
    end
  end

  assign out_p = sel_hdb3 ? dat_q[HDB3_SPAN] : dat_q[B3ZS_SPAN];
  assign out_n = sel_hdb3 ? aux_q[HDB3_SPAN] : aux_q[B3ZS_SPAN];
endmodule

// File: rtl/bsd_decoder.sv
module bsd_decoder #(
  parameter int unsigned HDB3_SPAN = 4,
  parameter int unsigned B3ZS_SPAN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic code_hdb3,
  input  logic nrz_mode,
  input  logic pos_in,
  input  logic neg_in,
  output logic pos_out,
  output logic neg_out
);
  localparam int unsigned SPAN_MAX = (HDB3_SPAN > B3ZS_SPAN) ? HDB3_SPAN : B3ZS_SPAN;
  localparam int unsigned ZC_W     = $clog2(SPAN_MAX + 1);

  logic cls_dec;
  logic cls_err;
  logic cls_drop;

  bsd_classify #(
    .HDB3_SPAN(HDB3_SPAN),
    .B3ZS_SPAN(B3ZS_SPAN),
    .SPAN_MAX (SPAN_MAX),
    .ZC_W     (ZC_W)
  ) classify_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .sel_hdb3 (code_hdb3),
    .rail_p   (pos_in),
    .rail_n   (neg_in),
    .dec_bit  (cls_dec),
    .err_bit  (cls_err),
    .drop_lead(cls_drop)
  );

  bsd_align #(
    .HDB3_SPAN(HDB3_SPAN),
    .B3ZS_SPAN(B3ZS_SPAN),
    .SPAN_MAX (SPAN_MAX)
  ) align_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .sel_hdb3 (code_hdb3),
    .nrz_mode (nrz_mode),
    .dec_bit  (cls_dec),
    .err_bit  (cls_err),
    .drop_lead(cls_drop),
    .rail_p   (pos_in),
    .rail_n   (neg_in),
    .out_p    (pos_out),
    .out_n    (neg_out)
  );
endmodule

// File: rtl/bsd_decoder_chk.sv
module bsd_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic pos_in,
  input logic neg_in,
  input logic pos_out,
  input logic neg_out,
  input logic cls_err,
  input logic cls_drop
);
  // R1: outputs held low during reset
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |-> (!pos_out && !neg_out));

  // R2: an edge without enable leaves the outputs untouched
  assert_hold_no_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(pos_out) && $stable(neg_out)));

  // R13: no flag or clear is raised outside an enabled bit
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> (!cls_err && !cls_drop));

  // R12: a pulse on both rails is always flagged
  assert_double_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && pos_in && neg_in) |-> cls_err);

  // R6: a lead clear comes only from an unflagged single-rail pulse
  assert_drop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cls_drop |-> (bit_en && (pos_in ^ neg_in) && !cls_err));
endmodule

bind bsd_decoder bsd_decoder_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_en  (bit_en),
  .pos_in  (pos_in),
  .neg_in  (neg_in),
  .pos_out (pos_out),
  .neg_out (neg_out),
  .cls_err (cls_err),
  .cls_drop(cls_drop)
);

// File: tb/bsd_decoder_tb.sv
module bsd_decoder_tb_top;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  logic rst_n, bit_en, code_hdb3, nrz_mode, pos_in, neg_in;
  logic pos_out, neg_out;

  always #(CLK_NS/2) clk = ~clk;

  bsd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .code_hdb3(code_hdb3),
    .nrz_mode(nrz_mode), .pos_in(pos_in), .neg_in(neg_in),
    .pos_out(pos_out), .neg_out(neg_out)
  );

  typedef struct {
    logic  d;
    logic  f;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int   n_checks = 0;
  int   n_err    = 0;
  bit   done     = 0;

  // Reference model state (from the requirements)
  logic m_last_pos, m_par;
  int   m_zc;
  int   m_h1, m_h2, m_h3;   // 0 zero, 1 pos, 2 neg, 3 both

  function automatic int span();
    return code_hdb3 ? 4 : 3;
  endfunction

  task automatic check(input logic ad, input logic af, input logic ed, input logic ef, input string tag);
    n_checks++;
    if (ad !== ed || af !== ef) begin
      n_err++;
      $display("FAIL %s: got p=%0b n=%0b expected p=%0b n=%0b", tag, ad, af, ed, ef);
    end
  endtask

  task automatic model(input logic p, input logic n, output logic d, output logic f, output logic rem);
    int sym, lead;
    logic zeros;
    sym = p && n ? 3 : (p ? 1 : (n ? 2 : 0));
    d = 0; f = 0; rem = 0;
    if (sym == 3) begin
      d = 1; f = 1; m_zc = 0;
    end else if (sym != 0) begin
      m_zc = 0;
      if (p == m_last_pos) begin
        zeros = code_hdb3 ? (m_h1 == 0 && m_h2 == 0) : (m_h1 == 0);
        lead  = code_hdb3 ? m_h3 : m_h2;
        if (zeros && lead != 3 && m_par) rem = (lead != 0);
        else begin d = 1; f = 1; end
        m_par = 0;
      end else begin
        d = 1; m_par = ~m_par; m_last_pos = p;
      end
    end else begin
      m_zc++;
      if (m_zc == span()) begin f = 1; m_zc = 0; end
    end
    m_h3 = m_h2; m_h2 = m_h1; m_h1 = sym;
  endtask

  // Driver: presents one symbol and queues the expected result
  task automatic send(input logic p, input logic n, input string tag);
    logic d, f, rem;
    exp_t e;
    @(negedge clk);
    pos_in = p; neg_in = n; bit_en = 1'b1;
    if (nrz_mode) model(p, n, d, f, rem);
    else begin d = p; f = n; rem = 0; end
    if (rem && q.size() > 0) q[0].d = 1'b0;
    e.d = d; e.f = f; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 4; i++) send(1'b0, 1'b0, tag);
  endtask

  task automatic idle(input int cyc);
    logic hp, hn;
    @(negedge clk);
    bit_en = 1'b0;
    hp = pos_out; hn = neg_out;
    repeat (cyc) @(negedge clk);
    check(pos_out, neg_out, hp, hn, "R2 hold while enable low");
  endtask

  task automatic do_reset(input logic hd, input logic nrz);
    @(negedge clk);
    bit_en = 1'b0; rst_n = 1'b0; pos_in = 0; neg_in = 0;
    code_hdb3 = hd; nrz_mode = nrz;
    q.delete();
    m_last_pos = 0; m_par = 0; m_zc = 0; m_h1 = 0; m_h2 = 0; m_h3 = 0;
    #1;
    check(pos_out, neg_out, 1'b0, 1'b0, "R1 outputs low in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rnd_stream(input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4) send(0, 0, tag);
      else if (r < 6) send(1, 0, tag);
      else if (r < 8) send(0, 1, tag);
      else if (r == 8) begin send(0, 0, tag); send(0, 0, tag); end
      else send(1, 1, tag);
      if (i % 97 == 50) idle(2);
    end
  endtask

  // Monitor: after each enabled edge, compares the oldest queued item
  always @(posedge clk) begin
    if (rst_n && bit_en && !done) begin
      #2;
      if (q.size() == span()) begin
        mon_e = q.pop_front();
        check(pos_out, neg_out, mon_e.d, mon_e.f, mon_e.tag);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; bit_en = 0; code_hdb3 = 1; nrz_mode = 1; pos_in = 0; neg_in = 0;
    #1 rst_n = 1'b0;

    // HDB3 decoding
    do_reset(1'b1, 1'b1);
    send(1,0,"R4"); send(0,1,"R4"); send(1,0,"R4"); send(0,0,"R4"); send(0,1,"R4");
    send(1,0,"R10"); send(0,0,"R6"); send(0,0,"R6"); idle(3); send(0,0,"R6"); send(1,0,"R6");
    send(0,1,"R6"); send(0,0,"R6"); send(0,0,"R6"); send(0,1,"R6");
    send(1,0,"R8"); send(1,0,"R8");
    send(0,1,"R8"); send(0,0,"R8"); send(0,1,"R8");
    send(0,0,"R9"); send(0,0,"R9"); send(0,0,"R9"); send(0,1,"R9");
    send(1,0,"R11");
    for (int i = 0; i < 8; i++) send(0,0,"R11");
    send(1,1,"R12"); send(0,1,"R12"); send(0,0,"R12"); send(0,0,"R12"); send(1,1,"R12");
    send(0,0,"R12"); send(0,0,"R12"); send(0,0,"R12");
    send(1,0,"R10"); send(0,1,"R10"); send(0,0,"R10"); send(0,0,"R10"); send(0,0,"R10"); send(0,1,"R10");
    flush("R13");

    // Polarity after reset
    do_reset(1'b1, 1'b1);
    send(0,1,"R5"); send(1,0,"R5"); send(1,0,"R5"); send(0,1,"R5");
    flush("R5");

    // B3ZS decoding
    do_reset(1'b0, 1'b1);
    send(1,0,"R7"); send(0,0,"R7"); send(0,0,"R7"); send(1,0,"R7");
    send(0,1,"R7"); send(0,0,"R7"); send(0,1,"R7");
    send(1,0,"R8"); send(1,0,"R8");
    send(0,0,"R9"); send(0,0,"R9"); send(1,0,"R9");
    send(0,1,"R11"); send(0,0,"R11"); send(0,0,"R11"); send(0,0,"R11");
    send(1,1,"R12"); send(1,0,"R12");
    flush("R13");

    // Pass-through
    do_reset(1'b1, 1'b0);
    send(1,0,"R3"); send(1,0,"R3"); send(1,1,"R3"); send(0,0,"R3"); send(0,1,"R3");
    for (int i = 0; i < 6; i++) send(0,0,"R3");
    send(0,1,"R3"); send(0,1,"R3");
    flush("R3");

    // Long mixed streams
    do_reset(1'b1, 1'b1); rnd_stream(600, "R10 hdb3 stream"); flush("R13");
    do_reset(1'b0, 1'b1); rnd_stream(600, "R10 b3zs stream"); flush("R13");
    do_reset(1'b0, 1'b0); rnd_stream(200, "R3 stream");       flush("R3");

    // Reset in mid-stream
    send(1,0,"R3"); send(0,1,"R3");
    do_reset(1'b1, 1'b1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule